// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the clock waveform for an I2C master. It also tells a byte engine when to act on SDA. Every period is a count of reference-clock cycles, programmed through three 32-bit timing words:

- SCL high time and SCL low time.
- The point inside the high phase where SDA is sampled.
- The point inside the low phase where new transmit data may be placed on SDA.
- The lead-in time after a START.
- The bus-free time after a STOP.

The hardware stretches both SCL phases by fixed amounts. The low phase lasts two cycles longer than its programmed count, and the high phase lasts seven cycles longer.

The byte engine asks for bus actions through a valid/ready command stream with four operations:

- START, from an idle bus.
- Clock one bit.
- Repeated START, while the bus is owned.
- STOP.

The generator answers with single-cycle strobes:

- a data-change point;
- a sample point;
- bit done;
- start, meaning pull SDA low now with SCL high;
- stop, meaning release SDA now with SCL high.

Between requests the generator parks SCL low for as long as needed. A slave that holds SCL low during a high phase freezes the high-phase count until the line is seen high.

The command stream follows these back-pressure rules:

- `cmd_ready` is high only while the generator is idle or parked.
- A command is taken in any cycle where both `cmd_valid` and `cmd_ready` are high.
- While `cmd_ready` is low, the engine holds `cmd_valid` and `cmd_op` steady.
- All other pins are plain level or strobe signals.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `bus_idle` and `cmd_ready` are 1, `scl_drive_low` is 0, and all strobes are 0.
- R2: Field positions are as follows. `timing0` holds the high count in bits 31:16 and the sample position in bits 15:0. `timing1` holds the low count in bits 31:16 and the data-change position in bits 15:0. `timing2` holds the bus-free count in bits 31:16 and the lead-in count in bits 15:0.
- R3: A command taken while parked starts a low phase. The low phase lasts low count + 2 cycles with `scl_drive_low` = 1. `drive_stb` pulses exactly once, in the cycle whose index equals the data-change position. The first cycle of the phase has index 0.
- R4: A high phase follows the low phase. It lasts high count + 7 cycles with `scl_drive_low` = 0. `sample_stb` pulses once, at index equal to the sample position.
- R5: While `scl_in` is low during a high phase, the high-phase count is held at zero, and neither `sample_stb` nor an end-of-phase strobe is raised. Counting resumes from zero once `scl_in` is high.
- R6: A START taken while idle raises `start_stb` in the acceptance cycle. SCL then stays released for max(lead-in, 1) cycles, after which the generator parks.
- R7: For a bit request, `bit_done` pulses in the last high-phase cycle. The generator then parks: `scl_drive_low` = 1 and `cmd_ready` = 1, held for as long as no command arrives.
- R8: A START taken while parked runs a low phase and a high phase. It raises `start_stb` in the last high cycle, then runs the lead-in and parks.
- R9: A STOP runs a low phase and a high phase. It raises `stop_stb` in the last high cycle. SCL then stays released with `cmd_ready` = 0 for max(bus-free, 1) cycles before the bus returns to idle.
- R10: Opcodes are 0 = no-op, 1 = START, 2 = bit, 3 = STOP. While idle, any opcode other than START is taken and has no effect. While parked, a no-op is taken and has no effect.
- R11: Each phase latches its counts when it begins. A timing word written during a phase affects only phases that begin later.
- R12: `cmd_ready` is 0 throughout the low, high, lead-in and bus-free phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing0 | input | 32 | High count and sample position |
| timing1 | input | 32 | Low count and data-change position |
| timing2 | input | 32 | Bus-free count and lead-in count |
| cmd_valid | input | 1 | Command request valid |
| cmd_op | input | 2 | Command opcode |
| cmd_ready | output | 1 | Command accepted when high with valid |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| start_stb | output | 1 | SDA falling point for a START |
| drive_stb | output | 1 | Transmit data-change point |
| sample_stb | output | 1 | Receive sample point |
| bit_done | output | 1 | Last cycle of a bit's high phase |
| stop_stb | output | 1 | SDA rising point for a STOP |
| bus_idle | output | 1 | Bus free, no transfer owned |

## Verification
Some properties are checked by assertions on every cycle:
- After a bit the clock parks low, and it stays low for as long as no request arrives.
- A STOP is always followed by released SCL with requests refused.
- A START is always followed by a lead-in with SCL high.
- Non-START requests never leave idle.
- The data-change point falls only while SCL is low, and the sample point only while it is high.
- No sample or end-of-phase strobe appears while a slave holds SCL low.

Other properties only the bench's scenarios can show, because they depend on the programmed counts:
- exact phase lengths, including the fixed offsets;
- the cycle index of each strobe;
- how far stretching delays the sample point;
- that a mid-phase write to a timing word is deferred to the next phase.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;

  typedef enum logic [2:0] {
    TG_IDLE  = 3'd0,
    TG_LEAD  = 3'd1,
    TG_PARK  = 3'd2,
    TG_LOW   = 3'd3,
    TG_HIGH  = 3'd4,
    TG_FREE  = 3'd5
  } tg_state_e;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_START = 2'd1,
    OP_BIT   = 2'd2,
    OP_STOP  = 2'd3
  } tg_op_e;

endpackage

// File: rtl/scl_field_split.sv
module scl_field_split #(
  parameter int REG_W  = 32,
  parameter int N_REGS = 3,
  localparam int FW    = REG_W / 2
) (
  input  logic [N_REGS*REG_W-1:0] regs_flat,
  output logic [N_REGS*FW-1:0]    upper_flat,
  output logic [N_REGS*FW-1:0]    lower_flat
);

  // Each timing word carries two half-width fields (R2).
  for (genvar i = 0; i < N_REGS; i++) begin : g_split
    assign upper_flat[i*FW +: FW] = regs_flat[i*REG_W + FW +: FW];
    assign lower_flat[i*FW +: FW] = regs_flat[i*REG_W +: FW];
  end

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int FW  = 16,
  localparam int CW = FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_lim,
  input  logic [FW-1:0] load_pos,
  input  logic          hold,
  output logic          at_pos,
  output logic          at_last
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic [FW-1:0] pos_q;
  logic [CW:0]   cnt_inc;

  // Limit and strobe position are captured once per phase (R11).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      pos_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      lim_q <= load_lim;
      pos_q <= load_pos;
    end else if (hold) begin
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign at_last = cnt_inc >= {1'b0, lim_q};
  assign at_pos  = cnt_q == {1'b0, pos_q};

endmodule

// File: rtl/scl_seq_fsm.sv
module scl_seq_fsm
  import scl_tgen_pkg::*;
#(
  parameter int FW         = 16,
  parameter int LOW_EXTRA  = 2,
  parameter int HIGH_EXTRA = 7,
  localparam int CW        = FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  output logic          cmd_ready,
  input  logic          scl_in,
  input  logic [FW-1:0] high_cnt,
  input  logic [FW-1:0] rx_pos,
  input  logic [FW-1:0] low_cnt,
  input  logic [FW-1:0] tx_pos,
  input  logic [FW-1:0] free_cnt,
  input  logic [FW-1:0] lead_cnt,
  input  logic          at_pos,
  input  logic          at_last,
  output logic          load,
  output logic [CW-1:0] load_lim,
  output logic [FW-1:0] load_pos,
  output logic          hold,
  output logic          scl_drive_low,
  output logic          start_stb,
  output logic          drive_stb,
  output logic          sample_stb,
  output logic          bit_done,
  output logic          stop_stb,
  output logic          bus_idle
);

  tg_state_e state_q, state_d;
  tg_op_e    op_q, op_d;
  logic      take;
  logic      high_end;
  logic [CW-1:0] low_lim, high_lim, lead_lim, free_lim;

  assign low_lim  = {1'b0, low_cnt}  + CW'(LOW_EXTRA);
  assign high_lim = {1'b0, high_cnt} + CW'(HIGH_EXTRA);
  assign lead_lim = {1'b0, lead_cnt};
  assign free_lim = {1'b0, free_cnt};

  // Requests are accepted only while idle or parked (R12).
  assign cmd_ready = (state_q == TG_IDLE) || (state_q == TG_PARK);
  assign take      = cmd_valid && cmd_ready;
  // A slave holding SCL low freezes the high count at zero (R5).
  assign hold      = (state_q == TG_HIGH) && !scl_in;
  assign high_end  = (state_q == TG_HIGH) && at_last && scl_in;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    load     = 1'b0;
    load_lim = '0;
    load_pos = '0;
    unique case (state_q)
      TG_IDLE: begin
        if (take && cmd_op == OP_START) begin
          state_d  = TG_LEAD;
          load     = 1'b1;
          load_lim = lead_lim;
        end
      end
      TG_LEAD: begin
        if (at_last) state_d = TG_PARK;
      end
      TG_PARK: begin
        if (take && cmd_op != OP_NOP) begin
          state_d  = TG_LOW;
          op_d     = tg_op_e'(cmd_op);
          load     = 1'b1;
          load_lim = low_lim;
          load_pos = tx_pos;
        end
      end
      TG_LOW: begin
        if (at_last) begin
          state_d  = TG_HIGH;
          load     = 1'b1;
          load_lim = high_lim;
          load_pos = rx_pos;
        end
      end
      TG_HIGH: begin
        if (high_end) begin
          unique case (op_q)
            OP_START: begin
              state_d  = TG_LEAD;
              load     = 1'b1;
              load_lim = lead_lim;
            end
            OP_STOP: begin
              state_d  = TG_FREE;
              load     = 1'b1;
              load_lim = free_lim;
            end
            default: state_d = TG_PARK;
          endcase
        end
      end
      TG_FREE: begin
        if (at_last) state_d = TG_IDLE;
      end
      default: state_d = TG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TG_IDLE;
      op_q    <= OP_NOP;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
    end
  end

  assign scl_drive_low = (state_q == TG_LOW) || (state_q == TG_PARK);
  assign bus_idle      = state_q == TG_IDLE;
  assign drive_stb     = (state_q == TG_LOW) && at_pos;
  assign sample_stb    = (state_q == TG_HIGH) && at_pos && scl_in;
  assign bit_done      = high_end && (op_q == OP_BIT);
  assign stop_stb      = high_end && (op_q == OP_STOP);
  assign start_stb     = (high_end && (op_q == OP_START)) ||
                         ((state_q == TG_IDLE) && take && (cmd_op == OP_START));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int REG_W      = 32,
  parameter int LOW_EXTRA  = 2,
  parameter int HIGH_EXTRA = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] timing0,
  input  logic [REG_W-1:0] timing1,
  input  logic [REG_W-1:0] timing2,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic             cmd_ready,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             start_stb,
  output logic             drive_stb,
  output logic             sample_stb,
  output logic             bit_done,
  output logic             stop_stb,
  output logic             bus_idle
);

  localparam int FW     = REG_W / 2;
  localparam int CW     = FW + 1;
  localparam int N_REGS = 3;

  logic [N_REGS*FW-1:0] upper_f, lower_f;
  logic                 load, hold, at_pos, at_last;
  logic [CW-1:0]        load_lim;
  logic [FW-1:0]        load_pos;

  scl_field_split #(.REG_W(REG_W), .N_REGS(N_REGS)) u_split (
    .regs_flat  ({timing2, timing1, timing0}),
    .upper_flat (upper_f),
    .lower_flat (lower_f)
  );

  scl_phase_cnt #(.FW(FW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_lim (load_lim),
    .load_pos (load_pos),
    .hold     (hold),
    .at_pos   (at_pos),
    .at_last  (at_last)
  );

  scl_seq_fsm #(
    .FW(FW), .LOW_EXTRA(LOW_EXTRA), .HIGH_EXTRA(HIGH_EXTRA)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_ready     (cmd_ready),
    .scl_in        (scl_in),
    .high_cnt      (upper_f[0*FW +: FW]),
    .rx_pos        (lower_f[0*FW +: FW]),
    .low_cnt       (upper_f[1*FW +: FW]),
    .tx_pos        (lower_f[1*FW +: FW]),
    .free_cnt      (upper_f[2*FW +: FW]),
    .lead_cnt      (lower_f[2*FW +: FW]),
    .at_pos        (at_pos),
    .at_last       (at_last),
    .load          (load),
    .load_lim      (load_lim),
    .load_pos      (load_pos),
    .hold          (hold),
    .scl_drive_low (scl_drive_low),
    .start_stb     (start_stb),
    .drive_stb     (drive_stb),
    .sample_stb    (sample_stb),
    .bit_done      (bit_done),
    .stop_stb      (stop_stb),
    .bus_idle      (bus_idle)
  );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_ready,
  input logic       scl_in,
  input logic       scl_drive_low,
  input logic       start_stb,
  input logic       drive_stb,
  input logic       sample_stb,
  input logic       bit_done,
  input logic       stop_stb,
  input logic       bus_idle
);

  // R7
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && cmd_ready && !cmd_valid) |=> scl_drive_low);

  // R7
  done_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> (scl_drive_low && cmd_ready));

  // R9
  stop_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> (!scl_drive_low && !cmd_ready && !bus_idle));

  // R6
  start_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> (!scl_drive_low && !cmd_ready));

  // R10
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && cmd_valid && cmd_op != 2'd1) |=> bus_idle);

  // R5
  stretch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_drive_low && !scl_in && !bus_idle) |-> (!sample_stb && !bit_done && !stop_stb));

  // R3
  drive_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_stb |-> scl_drive_low);

  // R3
  drive_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_stb |=> !drive_stb);

  // R4
  sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !scl_drive_low);

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .cmd_ready     (cmd_ready),
  .scl_in        (scl_in),
  .scl_drive_low (scl_drive_low),
  .start_stb     (start_stb),
  .drive_stb     (drive_stb),
  .sample_stb    (sample_stb),
  .bit_done      (bit_done),
  .stop_stb      (stop_stb),
  .bus_idle      (bus_idle)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] t0 = '0, t1 = '0, t2 = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_ready, scl_in, scl_drive_low, start_stb, drive_stb;
  logic        sample_stb, bit_done, stop_stb, bus_idle;
  logic        stretch_r = 1'b0;
  int          checks = 0;
  int          fails = 0;

  localparam logic [1:0] C_NOP = 2'd0, C_START = 2'd1, C_BIT = 2'd2, C_STOP = 2'd3;

  always #2 clk = ~clk;

  assign scl_in = !(scl_drive_low || stretch_r);

  scl_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .timing0(t0), .timing1(t1), .timing2(t2),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .start_stb(start_stb),
    .drive_stb(drive_stb), .sample_stb(sample_stb), .bit_done(bit_done),
    .stop_stb(stop_stb), .bus_idle(bus_idle)
  );

  // Vector order: scl_low, drive, sample, done, start, stop, idle, ready
  task automatic chk(input string tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {scl_drive_low, drive_stb, sample_stb, bit_done,
           start_stb, stop_stb, bus_idle, cmd_ready};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int atleast1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // START from idle (R6)
  task automatic idle_start(input string pfx);
    int li;
    li = atleast1(int'(t2[15:0]));
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = C_START;
    #1 chk({pfx, " R6 accept"}, 8'b0000_1011);
    @(posedge clk); #1 cmd_valid = 1'b0; cmd_op = C_NOP;
    for (int j = 1; j <= li + 1; j++) begin
      @(negedge clk); #1;
      if (j <= li) chk({pfx, " R6 lead-in"}, 8'b0000_0000);
      else         chk({pfx, " R6 park"},    8'b1000_0001);
    end
  endtask

  // Command issued while parked; checks every cycle to the following rest state.
  task automatic parked_op(input string pfx, input logic [1:0] op,
                           input int stretch, input bit poke, input logic [31:0] poke_val);
    int L, H, tx, rx, li, bf, sh, jend, tail, hk;
    logic e_low, e_drv, e_smp, e_done, e_st, e_sp, e_idle, e_rdy;
    string tag;
    L  = int'(t1[31:16]) + 2;  tx = int'(t1[15:0]);
    H  = int'(t0[31:16]) + 7;  rx = int'(t0[15:0]);
    li = atleast1(int'(t2[15:0]));
    bf = atleast1(int'(t2[31:16]));
    sh = (stretch == 0) ? 0 : stretch - 1;
    jend = L + H + sh;
    tail = (op == C_START) ? li : (op == C_STOP) ? bf : 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(posedge clk); #1 cmd_valid = 1'b0; cmd_op = C_NOP;
    for (int j = 1; j <= jend + tail + 1; j++) begin
      @(negedge clk);
      if (stretch > 0 && j == L) stretch_r = 1'b1;
      if (stretch > 0 && j == L + stretch) stretch_r = 1'b0;
      if (poke && j == 1) t1 = poke_val;
      #1;
      hk     = j - (L + 1) - sh;
      e_low  = (j <= L) || (j > jend + tail && op != C_STOP);
      e_drv  = (j <= L) && (j - 1 == tx);
      e_smp  = (j > L) && (j <= jend) && !stretch_r && (hk == rx);
      e_done = (j == jend) && (op == C_BIT);
      e_st   = (j == jend) && (op == C_START);
      e_sp   = (j == jend) && (op == C_STOP);
      e_idle = (j > jend + tail) && (op == C_STOP);
      e_rdy  = j > jend + tail;
      if (j <= L)                tag = poke ? " R11 low latched" : " R3 low phase";
      else if (j <= jend)        tag = (stretch > 0) ? " R5 stretched high" : " R4 high phase";
      else if (j <= jend + tail) tag = (op == C_START) ? " R8 repeated start" : " R9 bus free";
      else                       tag = (op == C_STOP) ? " R9 idle" : " R7 park";
      chk({pfx, tag}, {e_low, e_drv, e_smp, e_done, e_st, e_sp, e_idle, e_rdy});
    end
  endtask

  task automatic ignored(input string pfx, input logic [1:0] op, input logic [7:0] rest);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(posedge clk); #1 cmd_valid = 1'b0; cmd_op = C_NOP;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); #1 chk({pfx, " R10 ignored op"}, rest);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset", 8'b0000_0011);
    repeat (2) @(negedge clk);
    #1 chk("R1 reset hold", 8'b0000_0011);

    // Sweep of small timing configurations (R2 field positions, R3, R4, R12)
    for (int lo = 0; lo < 3; lo++)
      for (int hi = 0; hi < 2; hi++)
        for (int tx = 0; tx < 2; tx++)
          for (int rx = 0; rx < 2; rx++) begin
            t0 = {16'(hi), 16'(rx)};
            t1 = {16'(lo), 16'(tx)};
            t2 = {16'((hi == 1) ? 2 : 0), 16'((lo == 1) ? 0 : 3)};
            idle_start("R2 sweep");
            parked_op("R2 sweep", C_BIT, 0, 1'b0, '0);
            parked_op("R2 sweep", C_BIT, 3, 1'b0, '0);
            parked_op("R2 sweep", C_START, 0, 1'b0, '0);
            parked_op("R2 sweep", C_BIT, 1, 1'b0, '0);
            parked_op("R2 sweep", C_STOP, 0, 1'b0, '0);
          end

    // R10: non-START ops while idle, no-op while parked
    t0 = {16'd1, 16'd2}; t1 = {16'd2, 16'd1}; t2 = {16'd2, 16'd2};
    ignored("idle", C_BIT,  8'b0000_0011);
    ignored("idle", C_STOP, 8'b0000_0011);
    ignored("idle", C_NOP,  8'b0000_0011);
    idle_start("R10 setup");
    ignored("park", C_NOP,  8'b1000_0001);

    // R11: low count rewritten mid-phase applies only to the next low phase
    parked_op("R11", C_BIT, 0, 1'b1, {16'd5, 16'd4});
    parked_op("R11 next", C_BIT, 0, 1'b0, '0);
    parked_op("R11 end", C_STOP, 0, 1'b0, '0);

    // R2: standard-mode scale counts at the reference clock
    t0 = {16'd103, 16'd41}; t1 = {16'd128, 16'd48}; t2 = {16'd113, 16'd113};
    idle_start("R2 std");
    parked_op("R2 std", C_BIT, 0, 1'b0, '0);
    parked_op("R2 std", C_BIT, 20, 1'b0, '0);
    parked_op("R2 std", C_STOP, 0, 1'b0, '0);

    finish_run();
  end

endmodule